// File: doc/BRIEF.md
# Round-Key Schedule Generator with Indexed Store

This block turns one AES cipher key into the full set of 128-bit round keys and keeps them in a small indexed store. The key length is fixed for each instance by a parameter: 128, 192 or 256 bits. A key is handed over on a valid/ready handshake. The block then produces one 32-bit schedule word per clock cycle using the standard expansion: byte rotation, S-box substitution and the round constant. Every group of four words is written into the store as soon as it is complete.

A decryption datapath that sits next to this block reads the round keys by index. It can read them in any order, including from the last round key back to the first. The stored schedule stays valid and readable for any number of later blocks. A new key is only presented when the key actually changes. Loading a new key clears the valid flag and then overwrites the store with the new schedule.

Top module: `aes_key_sched`

## Requirements
- R1: After a synchronous active-high reset, `key_rdy` is 1 and `sched_ok` is 0.
- R2: The key is taken on a rising edge where `key_vld` and `key_rdy` are both 1. From the next cycle, `key_rdy` and `sched_ok` stay 0 for as long as the expansion runs.
- R3: `sched_ok` and `key_rdy` both return to 1 exactly 4*(NK+7) clock edges after the accepting edge, where NK = KEY_BITS/32. That is 44, 52 or 60 edges.
- R4: Read index r returns round key r of the standard expansion. Word 0 of the schedule is `key_in[KEY_BITS-1 -: 32]`. A round key is made of words 4r..4r+3, with word 4r in bits 127:96. The round constant starts at 0x01 and is multiplied by x in GF(2^8), modulo 0x11B, each time it is used.
- R5: `rk_out` presents the entry selected by `rk_idx` one clock edge after `rk_idx` is sampled. Back-to-back reads at different indices return one result per cycle.
- R6: A read at an index of NK+7 or above returns all zeros.
- R7: `key_vld` pulses while the expansion runs are ignored. The finished schedule belongs to the key that was accepted.
- R8: While no new key is accepted, `sched_ok` stays 1 and the store contents do not change, however long the block stays idle.
- R9: Accepting a new key drops `sched_ok` on the next cycle. When expansion completes, every entry holds the new key's schedule.
- R10: With 256-bit keys, a schedule word whose index modulo 8 equals 4 is built with S-box substitution only, without rotation or round constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| key_in | input | KEY_BITS | Cipher key, word 0 in the most significant bits |
| key_vld | input | 1 | Key present on `key_in` |
| key_rdy | output | 1 | Block idle and able to take a key |
| rk_idx | input | RK_IDX_W | Round-key read index |
| rk_out | output | 128 | Registered round key read from the store |
| sched_ok | output | 1 | Stored schedule complete and valid |

## Verification
The bench builds three instances at the same time, with KEY_BITS set to 256, 192 and 128, and drives them one after another through shared stimulus. Running all three lengths exercises each way the store can be filled: 15, 13 and 11 entries, and completion after 60, 52 or 44 cycles. The 256-bit instance is the only one that reaches the extra substitution-only step. The 192-bit instance is the only one where key-word boundaries do not line up with round-key boundaries. The 128-bit instance also reads a published final round key, which pins the bench's own reference model to a known value.

// File: rtl/kx_pkg.sv
package kx_pkg;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p;
    logic [7:0] m;
    p = 8'h00;
    m = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) p = p ^ m;
      m = xtime(m);
    end
    return p;
  endfunction

  // multiplicative inverse as x^254 (zero maps to zero)
  function automatic logic [7:0] gf_inv(input logic [7:0] x);
    logic [7:0] acc;
    logic [7:0] base;
    logic [7:0] expo;
    acc  = 8'h01;
    base = x;
    expo = 8'd254;
    for (int k = 0; k < 8; k++) begin
      if (expo[k]) acc = gf_mul(acc, base);
      base = gf_mul(base, base);
    end
    return acc;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] b, input int n);
    logic [15:0] d;
    d = {b, b} << n;
    return d[15:8];
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] x);
    logic [7:0] v;
    v = gf_inv(x);
    return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
  endfunction

endpackage

// File: rtl/kx_sbox_word.sv
module kx_sbox_word (
  input  logic [31:0] din,
  output logic [31:0] dout
);
  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign dout[8*g +: 8] = kx_pkg::sbox(din[8*g +: 8]);
  end
endmodule

// File: rtl/kx_word_gen.sv
module kx_word_gen #(
  parameter int NK = 8,
  localparam int KB = 32 * NK,
  localparam int PW = $clog2(NK)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          step,
  input  logic [KB-1:0] key,
  output logic [31:0]   word
);
  logic [31:0] win [NK];
  logic [PW-1:0] phase;
  logic          loaded;
  logic [7:0]    rcon;

  logic [31:0] tail, sin, sub, mix, fresh;
  logic        extra_hit;
  logic        ph0;

  assign tail = win[NK-1];
  assign ph0  = (phase == '0);
  assign sin  = ph0 ? {tail[23:0], tail[31:24]} : tail;

  kx_sbox_word u_sub (.din(sin), .dout(sub));

  if (NK > 6) begin : g_extra
    assign extra_hit = (phase == PW'(4));
  end else begin : g_noextra
    assign extra_hit = 1'b0;
  end

  always_comb begin
    if (ph0)            mix = sub ^ {rcon, 24'h0};
    else if (extra_hit) mix = sub;
    else                mix = tail;
  end

  assign fresh = win[0] ^ mix;
  assign word  = loaded ? fresh : win[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= '0;
      loaded <= 1'b0;
      rcon   <= 8'h01;
    end else if (start) begin
      phase  <= '0;
      loaded <= 1'b0;
      rcon   <= 8'h01;
    end else if (step) begin
      phase <= (phase == PW'(NK - 1)) ? '0 : phase + 1'b1;
      if (phase == PW'(NK - 1)) loaded <= 1'b1;
      if (loaded && ph0) rcon <= kx_pkg::xtime(rcon);
    end
  end

  // window: rotate through key words first, then shift in new words
  always_ff @(posedge clk) begin
    if (start) begin
      for (int k = 0; k < NK; k++) win[k] <= key[KB-1-32*k -: 32];
    end else if (step) begin
      for (int k = 0; k < NK - 1; k++) win[k] <= win[k+1];
      win[NK-1] <= word;
    end
  end
endmodule

// File: rtl/kx_round_store.sv
module kx_round_store #(
  parameter int DEPTH = 15,
  parameter int AW = 4,
  parameter int DW = 128
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];
  logic          rd_hit;

  assign rd_hit = ({1'b0, rd_idx} < (AW + 1)'(DEPTH));

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (rd_hit) rd_data <= mem[rd_idx];
    else             rd_data <= '0;
  end

  a_r4_wr_in_range: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ({1'b0, wr_addr} < (AW + 1)'(DEPTH)));

  a_r6_oob_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |=> (rd_data == '0));
endmodule

// File: rtl/aes_key_sched.sv
module aes_key_sched #(
  parameter int KEY_BITS = 256,
  localparam int NK = KEY_BITS / 32,
  localparam int NRK = NK + 7,
  localparam int NWORDS = 4 * NRK,
  localparam int CW = $clog2(NWORDS + 1),
  localparam int RK_IDX_W = $clog2(NRK)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [KEY_BITS-1:0] key_in,
  input  logic                key_vld,
  output logic                key_rdy,
  input  logic [RK_IDX_W-1:0] rk_idx,
  output logic [127:0]        rk_out,
  output logic                sched_ok
);
  logic          busy, accept, last;
  logic [CW-1:0] wcnt;
  logic [31:0]   word;
  logic [95:0]   acc;
  logic          wr_en;
  logic [RK_IDX_W-1:0] wr_addr;

  assign busy   = ~key_rdy;
  assign accept = key_vld & key_rdy;
  assign last   = busy && (wcnt == CW'(NWORDS - 1));
  assign wr_en  = busy && (wcnt[1:0] == 2'b11);
  assign wr_addr = RK_IDX_W'(wcnt >> 2);

  always_ff @(posedge clk) begin
    if (rst) begin
      key_rdy  <= 1'b1;
      sched_ok <= 1'b0;
      wcnt     <= '0;
    end else if (accept) begin
      key_rdy  <= 1'b0;
      sched_ok <= 1'b0;
      wcnt     <= '0;
    end else if (busy) begin
      wcnt <= wcnt + 1'b1;
      if (last) begin
        key_rdy  <= 1'b1;
        sched_ok <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (busy) acc <= {acc[63:0], word};
  end

  kx_word_gen #(.NK(NK)) u_gen (
    .clk(clk), .rst(rst), .start(accept), .step(busy),
    .key(key_in), .word(word)
  );

  kx_round_store #(.DEPTH(NRK), .AW(RK_IDX_W), .DW(128)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data({acc, word}), .rd_idx(rk_idx), .rd_data(rk_out)
  );

  // cycle counter for the completion-latency check
  logic [CW:0] a_cyc;
  always_ff @(posedge clk) begin
    if (rst)          a_cyc <= '0;
    else if (accept)  a_cyc <= '0;
    else if (busy)    a_cyc <= a_cyc + 1'b1;
  end

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (key_rdy && !sched_ok));

  a_r2_accept_blocks: assert property (@(posedge clk) disable iff (rst)
    (key_vld && key_rdy) |=> !key_rdy);

  a_r3_done_latency: assert property (@(posedge clk) disable iff (rst)
    $rose(sched_ok) |-> (a_cyc == (CW + 1)'(NWORDS)));

  a_r8_ok_holds: assert property (@(posedge clk) disable iff (rst)
    (sched_ok && !(key_vld && key_rdy)) |=> sched_ok);

  a_r9_reload_clears: assert property (@(posedge clk) disable iff (rst)
    (key_vld && key_rdy) |=> !sched_ok);
endmodule

// File: tb/tb_aes_key_sched.sv
`timescale 1ns/1ps
module tb_aes_key_sched;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [255:0] key_bus = '0;
  logic         kv = 1'b0;
  logic [3:0]   rk_idx = '0;
  int           sel = 0;

  logic         rdy [3];
  logic         ok  [3];
  logic [127:0] rko [3];

  aes_key_sched #(.KEY_BITS(256)) dut (
    .clk(clk), .rst(rst), .key_in(key_bus), .key_vld(kv && sel == 0),
    .key_rdy(rdy[0]), .rk_idx(rk_idx), .rk_out(rko[0]), .sched_ok(ok[0]));
  aes_key_sched #(.KEY_BITS(192)) dut192 (
    .clk(clk), .rst(rst), .key_in(key_bus[191:0]), .key_vld(kv && sel == 1),
    .key_rdy(rdy[1]), .rk_idx(rk_idx), .rk_out(rko[1]), .sched_ok(ok[1]));
  aes_key_sched #(.KEY_BITS(128)) dut128 (
    .clk(clk), .rst(rst), .key_in(key_bus[127:0]), .key_vld(kv && sel == 2),
    .key_rdy(rdy[2]), .rk_idx(rk_idx), .rk_out(rko[2]), .sched_ok(ok[2]));

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  task automatic chk(input bit good, input string tag,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!good) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [7:0]   sb [256];
  logic [127:0] exp_rk [15];

  function automatic logic [7:0] tmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 0;
    logic       hi;
    for (int k = 0; k < 8; k++) begin
      if (b[0]) p ^= a;
      hi = a[7];
      a = a << 1;
      if (hi) a ^= 8'h1b;
      b = b >> 1;
    end
    return p;
  endfunction

  task automatic init_sbox();
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv = 0;
      logic [7:0] s;
      for (int y = 1; y < 256; y++)
        if (tmul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      for (int i = 0; i < 8; i++)
        s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8]
             ^ inv[(i+7)%8] ^ (8'h63 >> i);
      sb[x] = s;
    end
  endtask

  function automatic logic [31:0] subw(input logic [31:0] w);
    return {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
  endfunction

  task automatic build_ref(input logic [255:0] key, input int nk);
    logic [31:0] w [60];
    logic [31:0] t;
    logic [7:0]  rc = 8'h01;
    for (int j = 0; j < nk; j++) w[j] = key[32*nk-1-32*j -: 32];
    for (int i = nk; i < 4*(nk+7); i++) begin
      t = w[i-1];
      if (i % nk == 0) begin
        t = subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
        rc = tmul(rc, 8'h02);
      end else if (nk > 6 && i % nk == 4) begin
        t = subw(t);
      end
      w[i] = w[i-nk] ^ t;
    end
    for (int r = 0; r < nk + 7; r++)
      exp_rk[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endtask

  // ---------------- scoreboard ----------------
  logic [127:0] exp_q [$];
  string        tag_q [$];

  task automatic read_rk(input int idx, input logic [127:0] exp, input string tag);
    @(negedge clk);
    rk_idx = 4'(idx);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [127:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(rko[sel] == e, t, rko[sel], e);
    end
  end

  task automatic drain();
    while (exp_q.size() > 0) @(posedge clk);
    @(negedge clk);
  endtask

  // ---------------- key load with timing checks ----------------
  task automatic load_key(input logic [255:0] key, input int nk,
                          input bit probe, input logic [255:0] other,
                          input string tag_clr);
    int k = 0;
    bit rdy_leak = 0;
    @(negedge clk);
    key_bus = key;
    kv = 1'b1;
    @(negedge clk);
    kv = 1'b0;
    chk(rdy[sel] == 1'b0, "R2 key_rdy low after accept", 128'(rdy[sel]), 128'd0);
    chk(ok[sel] == 1'b0, tag_clr, 128'(ok[sel]), 128'd0);
    while (k < 200) begin
      @(negedge clk);
      k++;
      if (ok[sel]) break;
      if (rdy[sel]) rdy_leak = 1;
      if (probe && k == 5) begin key_bus = other; kv = 1'b1; end  // R7 stray key
      if (probe && k == 6) begin kv = 1'b0; key_bus = key; end
    end
    chk(!rdy_leak, "R2 key_rdy stayed low while expanding", 128'(rdy_leak), 128'd0);
    chk(k == 4*(nk+7), "R3 completion edge count", 128'(k), 128'(4*(nk+7)));
    chk(rdy[sel] == 1'b1, "R3 key_rdy back high", 128'(rdy[sel]), 128'd1);
  endtask

  task automatic read_all(input int nk, input string tag);
    for (int r = nk + 6; r >= 0; r--) read_rk(r, exp_rk[r], tag);  // reverse order
    drain();
  endtask

  task automatic run_unit(input int s, input int nk, input logic [255:0] ka,
                          input logic [255:0] kb, input bit probe);
    sel = s;
    build_ref(ka, nk);
    load_key(ka, nk, probe, kb, "R2 sched_ok low after accept");
    read_all(nk, probe ? "R7 schedule of accepted key" :
                 (nk == 8 ? "R10 256-bit schedule" : "R4 round keys"));
    // R5: back-to-back reads, one result per cycle
    read_rk(0, exp_rk[0], "R5 back-to-back first");
    read_rk(nk + 6, exp_rk[nk+6], "R5 back-to-back second");
    read_rk(1, exp_rk[1], "R5 back-to-back third");
    drain();
    for (int r = nk + 7; r < 16; r++) read_rk(r, 128'd0, "R6 out-of-range index");
    drain();
    repeat (40) @(negedge clk);
    chk(ok[sel] == 1'b1, "R8 sched_ok held while idle", 128'(ok[sel]), 128'd1);
    read_rk(nk + 6, exp_rk[nk+6], "R8 last key persists");
    read_rk(2, exp_rk[2], "R8 key 2 persists");
    drain();
    build_ref(kb, nk);
    load_key(kb, nk, 1'b0, '0, "R9 sched_ok cleared by reload");
    read_all(nk, "R9 schedule after reload");
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    init_sbox();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int s = 0; s < 3; s++) begin
      chk(rdy[s] == 1'b1, "R1 key_rdy after reset", 128'(rdy[s]), 128'd1);
      chk(ok[s] == 1'b0, "R1 sched_ok after reset", 128'(ok[s]), 128'd0);
    end
    run_unit(0, 8,
      256'h603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4,
      256'h0123456789abcdeffedcba9876543210a5a5a5a55a5a5a5a0f0f0f0ff0f0f0f0, 1'b1);
    run_unit(1, 6,
      256'h8e73b0f7da0e6452c810f32b809079e562f8ead2522c6b7b,
      256'h0, 1'b0);
    run_unit(2, 4,
      256'hffffffffffffffffffffffffffffffff,
      256'h2b7e151628aed2a6abf7158809cf4f3c, 1'b0);
    // R4 anchor: published final round key for this 128-bit key
    read_rk(10, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6, "R4 known final round key");
    drain();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule